// File: doc/BRIEF.md
# Coherence-Aware Store Buffer with Load Forwarding

This block sits between one core's store port and that core's private cache controller. For every store it looks at the coherence state of the target line, supplied by the cache tags in the same cycle. A store to a line the core owns outright (Exclusive or Modified) goes straight to the cache when nothing older is waiting. A store to a Shared line, or to a line that is absent, is parked in a small private queue with its address and data. In the same cycle the block emits the matching coherence request, an invalidate for Shared and a read-with-invalidate for a miss. The core keeps issuing work while those requests are outstanding.

Loads look into the queue before the cache. When one or more parked stores match the load address, the youngest one supplies the data. Parked entries leave for the cache strictly oldest-first, and an entry may leave only once its acknowledgement has come back. A store barrier or an I/O operation puts the block into a drain phase in which new stores are held off until the queue is empty. A full queue holds off new stores until one entry leaves.

The control is a three-state machine: RUN (stores accepted), FULL (queue occupied to capacity, stores held) and DRAIN (forced emptying, stores held). RUN goes to FULL when an accepted store fills the last slot. RUN or FULL goes to DRAIN when a barrier or I/O request arrives while entries would remain. FULL returns to RUN when an entry retires. DRAIN returns to RUN in the cycle the last entry retires. A barrier that finds the queue already empty leaves the machine in RUN.

Top module: `stbuf_top`

## Requirements
- R1: A store accepted while the queue is empty and whose line state is Exclusive (2) or Modified (3) drives the cache write port in the same cycle with its address and data. No coherence request is issued and no queue entry is created.
- R2: An accepted store whose line state is Shared (1) is queued, and in the same cycle `msg_valid`=1, `msg_rdinv`=0 and `msg_addr` is the store address.
- R3: An accepted store whose line state is Invalid (0) is queued, and in the same cycle `msg_valid`=1 and `msg_rdinv`=1.
- R4: An Exclusive or Modified store accepted while the queue holds entries is queued without a coherence request and without a cache write. It later retires after all older entries and needs no acknowledgement.
- R5: While `ld_valid`=1, a load whose address matches a queued store returns the youngest matching data with `ld_fwd`=1. Otherwise `ld_fwd`=0 and `ld_data` equals `ld_cache_data`.
- R6: Each `ack_valid` pulse acknowledges the oldest queued entry still awaiting one. An entry does not reach the cache before its acknowledgement, and its cache write appears in the cycle after the acknowledgement is sampled. A pulse with no entry awaiting one has no effect.
- R7: Queued entries retire one per cycle in program order, and every cache write reports `cw_state` = Modified (3).
- R8: With 4 entries queued, `st_ready` is 0. It returns to 1 in the cycle after an entry retires.
- R9: A barrier pulse sampled while entries would remain holds `st_ready` at 0 from the next cycle until the cycle after the last entry retires. A barrier with an empty queue does not lower `st_ready`.
- R10: An I/O pulse has the same drain effect as a barrier.
- R11: After reset the queue is empty, `st_ready`=1, and `cw_valid`, `msg_valid` and `ld_fwd` are 0.
- R12: Outstanding acknowledgements do not stall the core: while the queue is neither full nor draining, `st_ready` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store request |
| st_addr | input | 32 | Store address |
| st_data | input | 32 | Store data |
| st_line_state | input | 2 | Coherence state of the store's line (0 I, 1 S, 2 E, 3 M) |
| st_ready | output | 1 | Store accepted when high together with st_valid |
| ld_valid | input | 1 | Load lookup request |
| ld_addr | input | 32 | Load address |
| ld_cache_data | input | 32 | Data the cache returns for the load |
| ld_data | output | 32 | Load result |
| ld_fwd | output | 1 | Load result came from the queue |
| ack_valid | input | 1 | Acknowledgement or response data for the oldest waiting request |
| bar_valid | input | 1 | Store barrier pulse |
| io_valid | input | 1 | I/O operation pulse |
| msg_valid | output | 1 | Coherence request valid |
| msg_rdinv | output | 1 | 1 read-with-invalidate, 0 invalidate |
| msg_addr | output | 32 | Coherence request address |
| cw_valid | output | 1 | Cache write strobe |
| cw_addr | output | 32 | Cache write address |
| cw_data | output | 32 | Cache write data |
| cw_state | output | 2 | Line state written with the data |

## Verification
Two events can coincide: an acknowledgement sampled for one entry and the retirement of the entry ahead of it. The bench provokes this by queueing three requests and sending acknowledgements on back-to-back cycles, so the second acknowledgement lands while the first acknowledged entry is leaving. It then requires the two following cache writes to carry the second and third entries in order, with no write skipped or repeated. A barrier pulse sent while entries wait is judged separately, through `st_ready` across the drain and the retirement that ends it.

// File: rtl/stbuf_pkg.sv
package stbuf_pkg;

    typedef enum logic [1:0] {
        LS_INV = 2'd0,
        LS_SHR = 2'd1,
        LS_EXC = 2'd2,
        LS_MOD = 2'd3
    } line_st_e;

    typedef enum logic [1:0] {
        PATH_DIRECT = 2'd0,
        PATH_INV    = 2'd1,
        PATH_RDINV  = 2'd2,
        PATH_QUIET  = 2'd3
    } st_path_e;

    typedef enum logic [1:0] {
        SB_RUN   = 2'd0,
        SB_FULL  = 2'd1,
        SB_DRAIN = 2'd2
    } sb_state_e;

endpackage

// File: rtl/stbuf_classify.sv
module stbuf_classify
    import stbuf_pkg::*;
(
    input  logic [1:0] line_st,
    input  logic       buf_empty,
    output st_path_e   path
);

    always_comb begin
        unique case (line_st_e'(line_st))
            LS_INV:  path = PATH_RDINV;
            LS_SHR:  path = PATH_INV;
            LS_EXC,
            LS_MOD:  path = buf_empty ? PATH_DIRECT : PATH_QUIET;
            default: path = PATH_RDINV;
        endcase
    end

endmodule

// File: rtl/stbuf_queue.sv
module stbuf_queue #(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int DEPTH = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [AW-1:0]    push_addr,
    input  logic [DW-1:0]    push_data,
    input  logic             push_done,
    input  logic             ack_in,
    input  logic [AW-1:0]    look_addr,
    output logic             look_hit,
    output logic [DW-1:0]    look_data,
    output logic             pop,
    output logic [AW-1:0]    head_addr,
    output logic [DW-1:0]    head_data,
    output logic [CNT_W-1:0] count
);

    logic [AW-1:0]    q_addr [DEPTH];
    logic [DW-1:0]    q_data [DEPTH];
    logic [DEPTH-1:0] q_done;
    logic [PTR_W-1:0] head, tail;

    logic [PTR_W-1:0] slot_of [DEPTH];
    logic [DEPTH-1:0] live;

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_age
            assign slot_of[g] = head + PTR_W'(g);
            assign live[g]    = CNT_W'(g) < count;
        end
    endgenerate

    logic             ack_found;
    logic [PTR_W-1:0] ack_slot;

    always_comb begin
        ack_found = 1'b0;
        ack_slot  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!ack_found && live[i] && !q_done[slot_of[i]]) begin
                ack_found = 1'b1;
                ack_slot  = slot_of[i];
            end
        end
    end

    always_comb begin
        look_hit  = 1'b0;
        look_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (live[i] && q_addr[slot_of[i]] == look_addr) begin
                look_hit  = 1'b1;
                look_data = q_data[slot_of[i]];
            end
        end
    end

    assign pop       = (count != '0) && q_done[head];
    assign head_addr = q_addr[head];
    assign head_data = q_data[head];

    always_ff @(posedge clk) begin
        if (push) begin
            q_addr[tail] <= push_addr;
            q_data[tail] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head   <= '0;
            tail   <= '0;
            count  <= '0;
            q_done <= '0;
        end else begin
            if (push) begin
                q_done[tail] <= push_done;
                tail         <= tail + PTR_W'(1);
            end
            if (ack_in && ack_found) begin
                q_done[ack_slot] <= 1'b1;
            end
            if (pop) begin
                head <= head + PTR_W'(1);
            end
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end

endmodule

// File: rtl/stbuf_ctrl.sv
module stbuf_ctrl
    import stbuf_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bar_req,
    input  logic             io_req,
    input  logic [CNT_W-1:0] count,
    input  logic             push,
    input  logic             pop,
    output logic             st_open
);

    sb_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_nxt;
    logic             force_drain;

    assign cnt_nxt     = count + CNT_W'(push) - CNT_W'(pop);
    assign force_drain = bar_req || io_req;

    always_comb begin
        unique case (state_q)
            SB_RUN, SB_FULL: begin
                if (force_drain && cnt_nxt != '0)
                    state_d = SB_DRAIN;
                else if (cnt_nxt == CNT_W'(DEPTH))
                    state_d = SB_FULL;
                else
                    state_d = SB_RUN;
            end
            SB_DRAIN: state_d = (cnt_nxt == '0) ? SB_RUN : SB_DRAIN;
            default:  state_d = SB_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SB_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        st_open = (state_q == SB_RUN);
    end

endmodule

// File: rtl/stbuf_top.sv
module stbuf_top
    import stbuf_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          st_valid,
    input  logic [AW-1:0] st_addr,
    input  logic [DW-1:0] st_data,
    input  logic [1:0]    st_line_state,
    output logic          st_ready,
    input  logic          ld_valid,
    input  logic [AW-1:0] ld_addr,
    input  logic [DW-1:0] ld_cache_data,
    output logic [DW-1:0] ld_data,
    output logic          ld_fwd,
    input  logic          ack_valid,
    input  logic          bar_valid,
    input  logic          io_valid,
    output logic          msg_valid,
    output logic          msg_rdinv,
    output logic [AW-1:0] msg_addr,
    output logic          cw_valid,
    output logic [AW-1:0] cw_addr,
    output logic [DW-1:0] cw_data,
    output logic [1:0]    cw_state
);

    st_path_e         path;
    logic             st_open, accept, direct, push, pop;
    logic             look_hit;
    logic [DW-1:0]    look_data;
    logic [AW-1:0]    head_addr;
    logic [DW-1:0]    head_data;
    logic [CNT_W-1:0] occ;

    stbuf_classify u_cls (
        .line_st   (st_line_state),
        .buf_empty (occ == '0),
        .path      (path)
    );

    stbuf_queue #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_addr (st_addr),
        .push_data (st_data),
        .push_done (path == PATH_QUIET),
        .ack_in    (ack_valid),
        .look_addr (ld_addr),
        .look_hit  (look_hit),
        .look_data (look_data),
        .pop       (pop),
        .head_addr (head_addr),
        .head_data (head_data),
        .count     (occ)
    );

    stbuf_ctrl #(.DEPTH(DEPTH)) u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .bar_req (bar_valid),
        .io_req  (io_valid),
        .count   (occ),
        .push    (push),
        .pop     (pop),
        .st_open (st_open)
    );

    assign st_ready  = st_open;
    assign accept    = st_valid && st_open;
    assign direct    = accept && (path == PATH_DIRECT);
    assign push      = accept && (path != PATH_DIRECT);

    assign msg_valid = accept && (path == PATH_INV || path == PATH_RDINV);
    assign msg_rdinv = (path == PATH_RDINV);
    assign msg_addr  = st_addr;

    assign cw_valid  = direct || pop;
    assign cw_addr   = pop ? head_addr : st_addr;
    assign cw_data   = pop ? head_data : st_data;
    assign cw_state  = LS_MOD;

    assign ld_fwd    = ld_valid && look_hit;
    assign ld_data   = ld_fwd ? look_data : ld_cache_data;

endmodule

// File: rtl/stbuf_chk.sv
module stbuf_chk #(
    parameter int DEPTH = 4,
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             st_valid,
    input logic             st_ready,
    input logic [1:0]       st_line_state,
    input logic             msg_valid,
    input logic             msg_rdinv,
    input logic             cw_valid,
    input logic [1:0]       cw_state,
    input logic             bar_valid,
    input logic             io_valid,
    input logic [CNT_W-1:0] occ
);

    AST_EXCL_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_ready && st_line_state[1] && occ == '0) |-> (cw_valid && !msg_valid)); // R1

    AST_SHARED_INV: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_ready && st_line_state == 2'd1) |-> (msg_valid && !msg_rdinv)); // R2

    AST_MISS_RDINV: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_ready && st_line_state == 2'd0) |-> (msg_valid && msg_rdinv)); // R3

    AST_QUIET_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_ready && st_line_state[1] && occ != '0) |-> !msg_valid); // R4

    AST_CW_MODIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        cw_valid |-> (cw_state == 2'd3)); // R7

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == CNT_W'(DEPTH)) |-> !st_ready); // R8

    AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((bar_valid || io_valid) && occ > CNT_W'(1)) |=> !st_ready); // R9

endmodule

bind stbuf_top stbuf_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .st_valid      (st_valid),
    .st_ready      (st_ready),
    .st_line_state (st_line_state),
    .msg_valid     (msg_valid),
    .msg_rdinv     (msg_rdinv),
    .cw_valid      (cw_valid),
    .cw_state      (cw_state),
    .bar_valid     (bar_valid),
    .io_valid      (io_valid),
    .occ           (occ)
);

// File: tb/sim_stbuf_top.sv
`timescale 1ns/1ps
module sim_stbuf_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_valid = 1'b0;
    logic [31:0] st_addr = '0;
    logic [31:0] st_data = '0;
    logic [1:0]  st_line_state = '0;
    logic        st_ready;
    logic        ld_valid = 1'b0;
    logic [31:0] ld_addr = '0;
    logic [31:0] ld_cache_data = 32'hCAFE0000;
    logic [31:0] ld_data;
    logic        ld_fwd;
    logic        ack_valid = 1'b0;
    logic        bar_valid = 1'b0;
    logic        io_valid = 1'b0;
    logic        msg_valid, msg_rdinv, cw_valid;
    logic [31:0] msg_addr, cw_addr, cw_data;
    logic [1:0]  cw_state;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    stbuf_top u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        st_valid = 0; ld_valid = 0; ack_valid = 0; bar_valid = 0; io_valid = 0;
    endtask

    task automatic cyc();
        @(posedge clk); #1;
        idle();
        #1;
    endtask

    task automatic store(input logic [1:0] ls, input logic [31:0] a, input logic [31:0] d);
        st_valid = 1; st_line_state = ls; st_addr = a; st_data = d; #1;
    endtask

    task automatic load(input logic [31:0] a);
        ld_valid = 1; ld_addr = a; #1;
    endtask

    task automatic drain_all();
        for (int k = 0; k < 10; k++) begin ack_valid = 1; cyc(); end
        repeat (2) cyc();
    endtask

    task automatic t_reset();
        chk("R11 st_ready", st_ready, 1);
        chk("R11 cw_valid", cw_valid, 0);
        chk("R11 msg_valid", msg_valid, 0);
        load(32'h100);
        chk("R11 ld_fwd", ld_fwd, 0);
        cyc();
    endtask

    task automatic t_direct();
        store(2'd3, 32'h800, 32'h88);
        chk("R1 cw_valid", cw_valid, 1);
        chk("R1 cw_addr", cw_addr, 32'h800);
        chk("R1 cw_data", cw_data, 32'h88);
        chk("R7 cw_state", cw_state, 3);
        chk("R1 msg_valid", msg_valid, 0);
        cyc();
        store(2'd2, 32'h804, 32'h99);
        chk("R1 E cw_valid", cw_valid, 1);
        chk("R1 E msg_valid", msg_valid, 0);
        cyc();
        load(32'h800);
        chk("R1 not queued", ld_fwd, 0);
        chk("R5 cache data", ld_data, 32'hCAFE0000);
        cyc();
    endtask

    task automatic t_shared_miss();
        store(2'd1, 32'h100, 32'h11);
        chk("R2 msg_valid", msg_valid, 1);
        chk("R2 msg_rdinv", msg_rdinv, 0);
        chk("R2 msg_addr", msg_addr, 32'h100);
        chk("R2 no cw", cw_valid, 0);
        cyc();
        store(2'd0, 32'h200, 32'h33);
        chk("R3 msg_valid", msg_valid, 1);
        chk("R3 msg_rdinv", msg_rdinv, 1);
        cyc();
        chk("R12 st_ready", st_ready, 1);
        store(2'd1, 32'h100, 32'h22);
        cyc();
        load(32'h100);
        chk("R5 fwd", ld_fwd, 1);
        chk("R5 youngest", ld_data, 32'h22);
        ld_addr = 32'h300; #1;
        chk("R5 miss fwd", ld_fwd, 0);
        chk("R5 miss data", ld_data, 32'hCAFE0000);
        chk("R6 no ack no cw", cw_valid, 0);
        ack_valid = 1;
        cyc();
        chk("R6 cw after ack", cw_valid, 1);
        chk("R7 oldest addr", cw_addr, 32'h100);
        chk("R7 oldest data", cw_data, 32'h11);
        cyc();
        chk("R6 wait second ack", cw_valid, 0);
        ack_valid = 1;
        cyc();
        chk("R7 second addr", cw_addr, 32'h200);
        chk("R7 second data", cw_data, 32'h33);
        ack_valid = 1;
        cyc();
        chk("R7 third valid", cw_valid, 1);
        chk("R7 third data", cw_data, 32'h22);
        cyc();
        chk("R7 empty", cw_valid, 0);
        load(32'h100);
        chk("R5 empty no fwd", ld_fwd, 0);
        cyc();
    endtask

    task automatic t_inorder();
        store(2'd1, 32'h400, 32'h44);
        cyc();
        store(2'd3, 32'h500, 32'h55);
        chk("R4 no msg", msg_valid, 0);
        chk("R4 no direct", cw_valid, 0);
        cyc();
        load(32'h500);
        chk("R4 queued fwd", ld_data, 32'h55);
        ack_valid = 1;
        cyc();
        chk("R4 older first", cw_addr, 32'h400);
        cyc();
        chk("R4 quiet retire", cw_valid, 1);
        chk("R4 quiet addr", cw_addr, 32'h500);
        cyc();
        chk("R4 done", cw_valid, 0);
    endtask

    task automatic t_full();
        for (int k = 0; k < 4; k++) begin
            store(2'd1, 32'h10 * (k + 1), k);
            cyc();
        end
        chk("R8 full stall", st_ready, 0);
        store(2'd1, 32'h999, 32'h9);
        chk("R8 no msg when held", msg_valid, 0);
        ack_valid = 1;
        cyc();
        chk("R8 retire", cw_addr, 32'h10);
        chk("R8 still held", st_ready, 0);
        cyc();
        chk("R8 reopen", st_ready, 1);
        drain_all();
    endtask

    task automatic t_drain(input bit use_io);
        store(2'd1, 32'h600, 32'h66);
        cyc();
        if (use_io) io_valid = 1; else bar_valid = 1;
        cyc();
        chk(use_io ? "R10 held" : "R9 held", st_ready, 0);
        cyc(); cyc();
        chk(use_io ? "R10 still held" : "R9 still held", st_ready, 0);
        ack_valid = 1;
        cyc();
        chk(use_io ? "R10 retire" : "R9 retire", cw_valid, 1);
        cyc();
        chk(use_io ? "R10 reopen" : "R9 reopen", st_ready, 1);
        if (use_io) io_valid = 1; else bar_valid = 1;
        cyc();
        chk(use_io ? "R10 empty no stall" : "R9 empty no stall", st_ready, 1);
    endtask

    task automatic t_stray_ack();
        ack_valid = 1;
        cyc();
        store(2'd1, 32'h700, 32'h77);
        cyc();
        chk("R6 stray ack ignored", cw_valid, 0);
        ack_valid = 1;
        cyc();
        chk("R6 real ack", cw_valid, 1);
        cyc();
    endtask

    bit finished = 0;

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        #1;
        t_reset();
        t_direct();
        t_shared_miss();
        t_inorder();
        t_full();
        t_drain(0);
        t_drain(1);
        t_stray_ack();
        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule